// File: doc/BRIEF.md
# Flash Block Lock Controller

This block decides whether a flash program or erase command may proceed. The array is split into a low region and a mid region, each made of a fixed number of blocks, and every block carries a lock bit. A primary volatile lock register covers all blocks. A secondary volatile lock register covers only the low blocks. A low block is locked when either register locks it, while a mid block follows the primary register alone. Software may rewrite either volatile register freely once the block is running.

Behind the volatile registers sits a one-time-programmable image with one word per register. A power-on pulse (`por_n`, which models the state at delivery) fills the image with ones, so every block starts locked. Writes to the image can only clear bits. After every functional reset a small state machine copies the image into the volatile registers: `ST_IDLE` (held in reset) goes to `ST_LOAD_PRI` on the first clock after reset is released. `ST_LOAD_PRI` copies the primary word and moves to `ST_LOAD_SEC`. `ST_LOAD_SEC` copies the secondary word and moves to `ST_READY`, which holds until the next reset. Any state returns to `ST_IDLE` while `rst_n` is low. Until `ST_READY` is reached, all blocks report locked and requests are stalled.

A request is taken on any cycle in which `req_valid` and `req_ready` are both high. The verdict appears one cycle later. A grant comes with a one-cycle start pulse toward the program/erase engine. A rejection comes with an error flag and no start pulse.

Top module: `flash_lock_ctrl`

## Requirements
- R1: A power-on pulse (`por_n` low at a clock edge) sets both image words to all ones, so after the following load `eff_lock` is all ones.
- R2: After `rst_n` is released, `init_done` and `req_ready` stay low for exactly two clock edges and rise with the third. Until then `eff_lock` reads all ones and no request is taken (`resp_valid` stays low on the following cycle).
- R3: During the load the primary register takes the primary image word, and then the secondary register takes the low `N_LOW` bits of the secondary image word.
- R4: Bit i of `eff_lock` (blocks 0..N_LOW-1 are low, N_LOW..NT-1 are mid) is the primary bit OR'd with the secondary bit for a low block, and the primary bit alone for a mid block. A secondary write never changes a mid bit.
- R5: A taken request whose block is locked gives, on the next cycle, `resp_valid`=1, `resp_reject`=1, `resp_grant`=0, and neither start pulse.
- R6: A taken request to an unlocked block gives, on the next cycle, `resp_grant`=1. It also gives `pgm_start`=1 when `req_op`=0 (program) or `ers_start`=1 when `req_op`=1 (erase).
- R7: A block index of NT or more is always rejected, even when every block is unlocked.
- R8: With `init_done` high, `lk_wr_en` writes `lk_wr_data` into the primary register (`lk_wr_sel`=0) or its low N_LOW bits into the secondary register (`lk_wr_sel`=1). Bits may be set or cleared, and the result shows on `eff_lock` after the edge. While `init_done` is low the write is ignored.
- R9: `img_wr_en` ANDs `img_wr_data` into the image word picked by `img_wr_sel` (0 primary, 1 secondary, low N_LOW bits). Image bits thus only fall, and a cleared bit cannot be set again. An image write leaves `eff_lock` untouched until the next load.
- R10: A request taken in the same cycle as a volatile write is judged on the lock state from before that write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset of the image, active low, synchronous |
| rst_n | input | 1 | Functional reset, active low, synchronous |
| lk_wr_en | input | 1 | Volatile lock register write strobe |
| lk_wr_sel | input | 1 | 0 primary, 1 secondary |
| lk_wr_data | input | NT | Volatile write value |
| img_wr_en | input | 1 | Image program strobe |
| img_wr_sel | input | 1 | 0 primary word, 1 secondary word |
| img_wr_data | input | NT | Image program value (ANDed in) |
| req_valid | input | 1 | Program/erase request present |
| req_op | input | 1 | 0 program, 1 erase |
| req_blk | input | IDXW | Target block index |
| req_ready | output | 1 | Request can be taken this cycle |
| resp_valid | output | 1 | Verdict for last cycle's request |
| resp_grant | output | 1 | Request allowed |
| resp_reject | output | 1 | Request refused, error flag |
| pgm_start | output | 1 | Start pulse for a program operation |
| ers_start | output | 1 | Start pulse for an erase operation |
| init_done | output | 1 | Image load complete |
| eff_lock | output | NT | Effective lock per block |

## Verification
Directed patterns go first. A request made while everything is still locked tells a correct reject apart from a stuck grant. A reload after partial image programming shows whether the two words land in the right registers. A low block locked only by the secondary register, next to a mid block locked only by the primary, shows whether the OR is limited to the low region. Out-of-range indices, a write and a request in the same cycle, and an attempt to relock through the image check the ordering and OTP rules. A long run of random writes, requests and functional resets then follows, compared each cycle against a behavioural model.

// File: rtl/flash_lock_pkg.sv
`timescale 1ns/1ps
package flash_lock_pkg;
    typedef enum logic [1:0] {
        ST_IDLE     = 2'd0,
        ST_LOAD_PRI = 2'd1,
        ST_LOAD_SEC = 2'd2,
        ST_READY    = 2'd3
    } lock_state_e;

    localparam logic SEL_PRIMARY   = 1'b0;
    localparam logic SEL_SECONDARY = 1'b1;
    localparam logic OP_PROGRAM    = 1'b0;
    localparam logic OP_ERASE      = 1'b1;
endpackage

// File: rtl/flash_lock_image.sv
`timescale 1ns/1ps
module flash_lock_image
    import flash_lock_pkg::*;
#(
    parameter int N_LOW = 4,
    parameter int N_MID = 2,
    localparam int NT = N_LOW + N_MID
) (
    input  logic             clk,
    input  logic             por_n,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [NT-1:0]    wr_data,
    output logic [NT-1:0]    img_pri,
    output logic [N_LOW-1:0] img_sec
);
    // One-time-programmable words: only a power-on sets bits, writes only clear them.
    always_ff @(posedge clk) begin
        if (!por_n) begin
            img_pri <= '1;
            img_sec <= '1;
        end else if (wr_en) begin
            if (wr_sel == SEL_PRIMARY) img_pri <= img_pri & wr_data;
            else                       img_sec <= img_sec & wr_data[N_LOW-1:0];
        end
    end

    // R9: no image bit ever rises while out of power-on
    p_otp_only_falls_r9: assert property (@(posedge clk) disable iff (!por_n)
        ((img_pri & ~$past(img_pri)) == '0) && ((img_sec & ~$past(img_sec)) == '0));
endmodule

// File: rtl/flash_lock_seq.sv
`timescale 1ns/1ps
module flash_lock_seq
    import flash_lock_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    output logic load_pri,
    output logic load_sec,
    output logic ready
);
    lock_state_e state, state_nx;

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_comb begin
        state_nx = state;
        load_pri = 1'b0;
        load_sec = 1'b0;
        ready    = 1'b0;
        unique case (state)
            ST_IDLE:     state_nx = ST_LOAD_PRI;
            ST_LOAD_PRI: begin
                load_pri = 1'b1;
                state_nx = ST_LOAD_SEC;
            end
            ST_LOAD_SEC: begin
                load_sec = 1'b1;
                state_nx = ST_READY;
            end
            ST_READY:    ready = 1'b1;
            default:     state_nx = ST_IDLE;
        endcase
    end

    // R2: the load steps happen once each, in order, before ready
    p_sec_after_pri_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_pri |=> load_sec);
    p_ready_after_sec_r2: assert property (@(posedge clk) disable iff (!rst_n)
        load_sec |=> ready);
endmodule

// File: rtl/flash_lock_bank.sv
`timescale 1ns/1ps
module flash_lock_bank
    import flash_lock_pkg::*;
#(
    parameter int N_LOW = 4,
    parameter int N_MID = 2,
    localparam int NT = N_LOW + N_MID
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load_pri,
    input  logic             load_sec,
    input  logic [NT-1:0]    img_pri,
    input  logic [N_LOW-1:0] img_sec,
    input  logic             wr_en,
    input  logic             wr_sel,
    input  logic [NT-1:0]    wr_data,
    output logic [NT-1:0]    raw_lock
);
    logic [NT-1:0]    pri_q;
    logic [N_LOW-1:0] sec_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            pri_q <= '1;
            sec_q <= '1;
        end else begin
            if (load_pri)                             pri_q <= img_pri;
            else if (wr_en && wr_sel == SEL_PRIMARY)  pri_q <= wr_data;
            if (load_sec)                             sec_q <= img_sec;
            else if (wr_en && wr_sel == SEL_SECONDARY) sec_q <= wr_data[N_LOW-1:0];
        end
    end

    for (genvar b = 0; b < NT; b++) begin : g_blk
        if (b < N_LOW) begin : g_low
            assign raw_lock[b] = pri_q[b] | sec_q[b];
        end else begin : g_mid
            assign raw_lock[b] = pri_q[b];
        end
    end

    // R4: a secondary write leaves the mid blocks alone
    p_mid_ignores_sec_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_SECONDARY && !load_pri && !load_sec)
        |=> $stable(raw_lock[NT-1:N_LOW]));
endmodule

// File: rtl/flash_lock_req.sv
`timescale 1ns/1ps
module flash_lock_req
    import flash_lock_pkg::*;
#(
    parameter int N_LOW = 4,
    parameter int N_MID = 2,
    localparam int NT   = N_LOW + N_MID,
    localparam int IDXW = $clog2(NT + 1)
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            fire,
    input  logic            op,
    input  logic [IDXW-1:0] blk,
    input  logic [NT-1:0]   lock_vec,
    output logic            resp_valid,
    output logic            resp_grant,
    output logic            resp_reject,
    output logic            pgm_start,
    output logic            ers_start
);
    logic hit, in_range, allow;

    always_comb begin
        hit      = 1'b0;
        in_range = 1'b0;
        for (int i = 0; i < NT; i++) begin
            if (blk == IDXW'(i)) begin
                in_range = 1'b1;
                hit      = lock_vec[i];
            end
        end
        allow = in_range && !hit;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            resp_valid  <= 1'b0;
            resp_grant  <= 1'b0;
            resp_reject <= 1'b0;
            pgm_start   <= 1'b0;
            ers_start   <= 1'b0;
        end else begin
            resp_valid  <= fire;
            resp_grant  <= fire && allow;
            resp_reject <= fire && !allow;
            pgm_start   <= fire && allow && (op == OP_PROGRAM);
            ers_start   <= fire && allow && (op == OP_ERASE);
        end
    end

    // R5: a locked target is refused and launches nothing
    p_locked_refused_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && in_range && lock_vec[blk[IDXW-1:0] < IDXW'(NT) ? blk : '0])
        |=> (resp_reject && !pgm_start && !ers_start));
    // R7: out-of-range indices are refused
    p_range_refused_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (fire && !in_range) |=> resp_reject);
endmodule

// File: rtl/flash_lock_ctrl.sv
`timescale 1ns/1ps
module flash_lock_ctrl
    import flash_lock_pkg::*;
#(
    parameter int N_LOW = 4,
    parameter int N_MID = 2,
    localparam int NT   = N_LOW + N_MID,
    localparam int IDXW = $clog2(NT + 1)
) (
    input  logic            clk,
    input  logic            por_n,
    input  logic            rst_n,
    input  logic            lk_wr_en,
    input  logic            lk_wr_sel,
    input  logic [NT-1:0]   lk_wr_data,
    input  logic            img_wr_en,
    input  logic            img_wr_sel,
    input  logic [NT-1:0]   img_wr_data,
    input  logic            req_valid,
    input  logic            req_op,
    input  logic [IDXW-1:0] req_blk,
    output logic            req_ready,
    output logic            resp_valid,
    output logic            resp_grant,
    output logic            resp_reject,
    output logic            pgm_start,
    output logic            ers_start,
    output logic            init_done,
    output logic [NT-1:0]   eff_lock
);
    logic [NT-1:0]    img_pri;
    logic [N_LOW-1:0] img_sec;
    logic [NT-1:0]    raw_lock;
    logic             load_pri, load_sec, ready;

    flash_lock_image #(.N_LOW(N_LOW), .N_MID(N_MID)) u_image (
        .clk(clk), .por_n(por_n), .wr_en(img_wr_en), .wr_sel(img_wr_sel),
        .wr_data(img_wr_data), .img_pri(img_pri), .img_sec(img_sec)
    );

    flash_lock_seq u_seq (
        .clk(clk), .rst_n(rst_n), .load_pri(load_pri), .load_sec(load_sec), .ready(ready)
    );

    flash_lock_bank #(.N_LOW(N_LOW), .N_MID(N_MID)) u_bank (
        .clk(clk), .rst_n(rst_n), .load_pri(load_pri), .load_sec(load_sec),
        .img_pri(img_pri), .img_sec(img_sec), .wr_en(lk_wr_en && ready),
        .wr_sel(lk_wr_sel), .wr_data(lk_wr_data), .raw_lock(raw_lock)
    );

    assign init_done = ready;
    assign req_ready = ready;
    assign eff_lock  = ready ? raw_lock : '1;

    flash_lock_req #(.N_LOW(N_LOW), .N_MID(N_MID)) u_req (
        .clk(clk), .rst_n(rst_n), .fire(req_valid && ready), .op(req_op),
        .blk(req_blk), .lock_vec(eff_lock), .resp_valid(resp_valid),
        .resp_grant(resp_grant), .resp_reject(resp_reject),
        .pgm_start(pgm_start), .ers_start(ers_start)
    );

    // R2: stalled requests produce no verdict
    p_no_verdict_unless_taken_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !(req_valid && req_ready) |=> !resp_valid);
    // R2: everything reads locked until the load is complete
    p_locked_while_loading_r2: assert property (@(posedge clk) disable iff (!rst_n)
        !init_done |-> (&eff_lock));
    // R6: exactly one verdict per response
    p_one_verdict_r6: assert property (@(posedge clk) disable iff (!rst_n)
        resp_valid |-> (resp_grant ^ resp_reject));
    // R6: a start pulse only with a grant, never both kinds
    p_start_needs_grant_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (pgm_start || ers_start) |-> (resp_grant && !(pgm_start && ers_start)));
    // R8: no volatile change while not ready (image load aside)
    p_hold_before_ready_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!init_done && !load_pri && !load_sec) |=> $stable(raw_lock));
endmodule

// File: tb/sim_flash_lock_ctrl.sv
`timescale 1ns/1ps
module sim_flash_lock_ctrl;
    localparam int NL = 4, NM = 2, NT = 6, IW = 3;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic por_n = 1'b0, rst_n = 1'b0;
    logic lk_wr_en = 0, lk_wr_sel = 0, img_wr_en = 0, img_wr_sel = 0;
    logic [NT-1:0] lk_wr_data = '0, img_wr_data = '0;
    logic req_valid = 0, req_op = 0;
    logic [IW-1:0] req_blk = '0;
    logic req_ready, resp_valid, resp_grant, resp_reject, pgm_start, ers_start, init_done;
    logic [NT-1:0] eff_lock;

    flash_lock_ctrl #(.N_LOW(NL), .N_MID(NM)) u0 (.*);

    int checks = 0, fails = 0, cyc = 0;
    bit done = 0;
    string phase = "R1";

    // behavioural reference
    logic [NT-1:0] m_img_p, m_vol_p;
    logic [NL-1:0] m_img_s, m_vol_s;
    int m_ld = 0;
    bit m_rv = 0, m_rg = 0, m_rr = 0, m_ps = 0, m_es = 0;

    function automatic logic [NT-1:0] m_eff();
        logic [NT-1:0] e;
        if (m_ld < 3) return '1;
        e = m_vol_p;
        e[NL-1:0] = e[NL-1:0] | m_vol_s;
        return e;
    endfunction

    always @(posedge clk) begin
        logic [NT-1:0] op, e;
        logic [NL-1:0] os;
        bit lk;
        op = m_img_p; os = m_img_s; e = m_eff();
        if (!por_n) begin m_img_p = '1; m_img_s = '1; end
        else if (img_wr_en) begin
            if (!img_wr_sel) m_img_p = m_img_p & img_wr_data;
            else             m_img_s = m_img_s & img_wr_data[NL-1:0];
        end
        m_rv = 0; m_rg = 0; m_rr = 0; m_ps = 0; m_es = 0;
        if (!rst_n) begin
            m_ld = 0; m_vol_p = '1; m_vol_s = '1;
        end else if (m_ld < 3) begin
            if (m_ld == 1) m_vol_p = op;
            if (m_ld == 2) m_vol_s = os;
            m_ld++;
        end else begin
            if (req_valid) begin
                lk = (int'(req_blk) >= NT) ? 1'b1 : e[req_blk];
                m_rv = 1; m_rg = !lk; m_rr = lk;
                m_ps = !lk && !req_op; m_es = !lk && req_op;
            end
            if (lk_wr_en) begin
                if (lk_wr_sel) m_vol_s = lk_wr_data[NL-1:0];
                else           m_vol_p = lk_wr_data;
            end
        end
    end

    task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    always @(negedge clk) begin
        if (!done && cyc > 0) begin
            chk(phase, "init_done", 32'(init_done), 32'(m_ld == 3));
            chk(phase, "req_ready", 32'(req_ready), 32'(m_ld == 3));
            chk(phase, "eff_lock", 32'(eff_lock), 32'(m_eff()));
            chk(phase, "resp_valid", 32'(resp_valid), 32'(m_rv));
            chk(phase, "resp_grant", 32'(resp_grant), 32'(m_rg));
            chk(phase, "resp_reject", 32'(resp_reject), 32'(m_rr));
            chk(phase, "pgm_start", 32'(pgm_start), 32'(m_ps));
            chk(phase, "ers_start", 32'(ers_start), 32'(m_es));
        end
    end

    task automatic summary();
        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=100000", cyc);
            summary();
        end
    end

    task automatic tick(int n = 1);
        for (int i = 0; i < n; i++) begin @(posedge clk); #1; end
    endtask

    task automatic request(int blk, bit op);
        req_valid = 1; req_blk = IW'(blk); req_op = op;
        tick();
        req_valid = 0;
        tick();
    endtask

    task automatic vwrite(bit sel, logic [NT-1:0] d);
        lk_wr_en = 1; lk_wr_sel = sel; lk_wr_data = d;
        tick();
        lk_wr_en = 0;
    endtask

    task automatic iwrite(bit sel, logic [NT-1:0] d);
        img_wr_en = 1; img_wr_sel = sel; img_wr_data = d;
        tick();
        img_wr_en = 0;
    endtask

    task automatic func_reset();
        rst_n = 0; tick(2); rst_n = 1;
    endtask

    initial begin
        phase = "R1";
        tick(3);
        por_n = 1; rst_n = 1;
        phase = "R2";
        req_valid = 1; req_blk = 0;
        tick();
        chk("R2", "init_done mid-load", 32'(init_done), 0);
        tick();
        req_valid = 0;
        tick();
        chk("R2", "init_done after load", 32'(init_done), 1);
        chk("R1", "all locked after delivery", 32'(eff_lock), 32'h3F);

        phase = "R5";
        request(0, 0);
        request(5, 1);

        phase = "R9";
        iwrite(0, ~6'b010011);
        iwrite(1, ~6'b000101);
        chk("R9", "image write leaves eff_lock", 32'(eff_lock), 32'h3F);
        func_reset();
        phase = "R3";
        tick(4);
        chk("R3", "reloaded locks", 32'(eff_lock), 32'h2E);

        phase = "R6";
        request(0, 0);
        request(4, 1);
        phase = "R4";
        request(1, 0);
        vwrite(1, 6'b000000);
        chk("R4", "sec clear unlocks low block 1", 32'(eff_lock), 32'h2C);
        request(1, 1);
        vwrite(1, 6'b111111);
        chk("R4", "sec set leaves mid", 32'(eff_lock[5:4]), 32'h2);
        request(4, 0);

        phase = "R8";
        vwrite(0, 6'b111111);
        request(4, 0);
        vwrite(0, 6'b000000);
        vwrite(1, 6'b000000);
        chk("R8", "all unlocked", 32'(eff_lock), 32'h0);

        phase = "R10";
        lk_wr_en = 1; lk_wr_sel = 0; lk_wr_data = 6'b111111;
        req_valid = 1; req_blk = 2; req_op = 0;
        tick();
        lk_wr_en = 0; req_valid = 0;
        chk("R10", "same-cycle write uses old state", 32'(resp_grant), 1);
        request(2, 0);

        phase = "R7";
        vwrite(0, 6'b000000);
        request(6, 0);
        request(7, 1);

        phase = "R9";
        iwrite(0, 6'b111111);
        iwrite(1, 6'b111111);
        func_reset();
        tick(4);
        chk("R9", "image cannot relock", 32'(eff_lock), 32'h2E);

        phase = "R8";
        func_reset();
        lk_wr_en = 1; lk_wr_sel = 0; lk_wr_data = 6'b0;
        tick();
        lk_wr_en = 0;
        tick(3);
        chk("R8", "write during load ignored", 32'(eff_lock), 32'h2E);

        phase = "R6";
        for (int k = 0; k < 3000; k++) begin
            rst_n       = ($urandom_range(0, 59) != 0);
            lk_wr_en    = ($urandom_range(0, 3) == 0);
            lk_wr_sel   = 1'($urandom);
            lk_wr_data  = NT'($urandom);
            img_wr_en   = ($urandom_range(0, 49) == 0);
            img_wr_sel  = 1'($urandom);
            img_wr_data = NT'($urandom) | NT'($urandom);
            req_valid   = 1'($urandom);
            req_op      = 1'($urandom);
            req_blk     = IW'($urandom);
            tick();
        end
        rst_n = 1; lk_wr_en = 0; img_wr_en = 0; req_valid = 0;
        tick(4);

        phase = "R1";
        por_n = 0; rst_n = 0;
        tick(2);
        por_n = 1; rst_n = 1;
        tick(4);
        chk("R1", "power-on restores all locked", 32'(eff_lock), 32'h3F);
        summary();
    end
endmodule